// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block sits behind a host register port and turns 16-bit host addresses into accesses on a small on-chip memory space. The host loads an address register, then reads or writes a 16-bit data register. Each data access moves two consecutive bytes, most significant byte at the lower address. The space holds a 1 KiB system RAM at 0x0000–0x03FF, a table-base register at 0x1050/0x1051 and a watchdog restart register at 0x1040. Bit 15 of every host address is dropped.

Addresses 0x0000–0x1FFF are physical and used as they are. Addresses 0x2000–0x3FFF are virtual: bits [11:8] pick one of 16 page pointers, and bits [7:0] are an offset added to that pointer. The pointers are 16-bit big-endian words stored in system RAM, starting at the table-base register. The upper window 0x3000–0x3FFF is an image of 0x2000–0x2FFF. A watchdog counter resets the translation state unless software keeps restarting it.

The controller is a state machine. S_CLEAR zeroes the 32 table bytes. S_IDLE waits for a request. S_PTR_HI and S_PTR_LO fetch the page pointer for a virtual address. S_DATA_HI and S_DATA_LO move the high and low data bytes. Its transitions are:
- clear-done: S_CLEAR to S_IDLE after the last table byte.
- start-physical: S_IDLE to S_DATA_HI.
- start-virtual: S_IDLE to S_PTR_HI.
- fetch-low: S_PTR_HI to S_PTR_LO.
- translate: S_PTR_LO to S_DATA_HI.
- byte-step: S_DATA_HI to S_DATA_LO.
- finish: S_DATA_LO to S_IDLE.
- watchdog-clear: S_IDLE to S_CLEAR.

Top module: `vpage_xlate`

## Requirements
- R1: While `rst` is high, `busy` is 1 and `rd_done`, `wd_reset` and `host_rdata` are 0. After `rst` falls, the block spends exactly 32 cycles writing zero to bytes 0x0100–0x011F, then drops `busy`.
- R2: A data write to a physical address A in 0x0000–0x03FF stores bits [15:8] at A and bits [7:0] at A+1. A later read of A returns {byte A, byte A+1}. Odd addresses are allowed.
- R3: Bit 15 of the address register is ignored, so 0x8000–0xFFFF reach the same locations as 0x0000–0x7FFF.
- R4: Writes to physical addresses 0x0400 and above are ignored, except for the registers named in R5 and R9. Reads of unmapped addresses return 0.
- R5: The table base is a 16-bit register at 0x1050 (high byte) and 0x1051 (low byte). It resets to 0x0100, can be read and written there, and relocates the page table.
- R6: For a virtual address in 0x2000–0x2FFF, the page pointer P is the big-endian word at base + 2×addr[11:8]. The access goes to P + addr[7:0]. This holds for both reads and writes.
- R7: Addresses in 0x3000–0x3FFF translate exactly like the address with bit 12 cleared.
- R8: If the page pointer is 0x2000 or greater, a read through that page returns 0 and a write through it changes nothing.
- R9: A data write of 0x0000 to 0x1040 restarts the watchdog count. A write of any other value does not.
- R10: When WDOG_CYCLES cycles pass without a restart, `wd_reset` pulses for one cycle. The table base then returns to 0x0100 and bytes 0x0100–0x011F are cleared. All other RAM bytes keep their contents.
- R11: Request handshake:
  - `host_wr` with `host_sel`=0 loads the address register. `host_wr` with `host_sel`=1 starts a write. `host_rd` starts a read.
  - A request is accepted only while `busy` is 0.
  - `rd_done` pulses once with valid `host_rdata`, on the 3rd clock edge after the request edge for a physical address and on the 5th for a virtual one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host data read strobe |
| host_sel | input | 1 | Write target: 0 = address register, 1 = data register |
| host_wdata | input | 16 | Host write value |
| host_rdata | output | 16 | Last 16-bit read result |
| rd_done | output | 1 | One-cycle pulse when `host_rdata` is updated |
| busy | output | 1 | Block cannot accept a request |
| wd_reset | output | 1 | One-cycle pulse on watchdog expiry |

## Verification
The assertions assume that the host raises at most one of `host_wr` and `host_rd` at a time and only while `busy` is low. They also assume that WDOG_CYCLES is at least 2, so that a watchdog pulse always ends. The bench keeps to both conditions: every access task first waits for `busy` to fall, drives a single one-cycle strobe, and uses the default watchdog limit. The bench never reads a RAM byte it has not written before, because system RAM has no reset value; only the table bytes are cleared.

// File: rtl/vpage_pkg.sv
package vpage_pkg;

    typedef enum logic [2:0] {
        S_CLEAR,
        S_IDLE,
        S_PTR_HI,
        S_PTR_LO,
        S_DATA_HI,
        S_DATA_LO
    } xl_state_e;

    localparam int unsigned PAGE_COUNT = 16;
    localparam int unsigned TBL_BYTES  = 2 * PAGE_COUNT;
    localparam int unsigned CIW        = $clog2(TBL_BYTES);

    // Virtual window: 0x2000-0x3FFF once bit 15 is dropped.
    function automatic logic is_virtual(input logic [14:0] a);
        return a[14:13] == 2'b01;
    endfunction

endpackage

// File: rtl/vpage_sysram.sv
module vpage_sysram #(
    parameter int unsigned BYTES = 1024,
    localparam int unsigned AW   = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/vpage_watchdog.sv
module vpage_watchdog #(
    parameter int unsigned LIMIT = 2000,
    localparam int unsigned CW   = $clog2(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick,
    output logic [CW-1:0] cnt,
    output logic          fire
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          fire_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            fire_q <= 1'b0;
        end else begin
            fire_q <= (cnt_q == LAST) && !kick;
            if (kick || cnt_q == LAST) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt  = cnt_q;
    assign fire = fire_q;

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
    parameter int unsigned RAM_BYTES   = 1024,
    parameter int unsigned WDOG_CYCLES = 2000,
    parameter logic [15:0] TBL_RESET   = 16'h0100,
    parameter logic [14:0] KICK_ADDR   = 15'h1040,
    parameter logic [14:0] BASE_ADDR   = 15'h1050
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        rd_done,
    output logic        busy,
    output logic        wd_reset
);
    import vpage_pkg::*;

    localparam int unsigned RAM_AW = $clog2(RAM_BYTES);
    localparam int unsigned WCW    = $clog2(WDOG_CYCLES);
    localparam logic [14:0] RAM_TOP = 15'(RAM_BYTES);
    localparam logic [CIW-1:0] CLR_LAST = CIW'(TBL_BYTES - 1);

    xl_state_e state_q, state_d;

    logic [14:0]     addr_q;
    logic [15:0]     wdat_q;
    logic            op_wr_q;
    logic [7:0]      ptr_hi_q;
    logic [14:0]     tgt_q;
    logic            zflag_q;
    logic [7:0]      rbuf_q;
    logic [15:0]     rdata_q;
    logic            rd_done_q;
    logic [15:0]     base_q;
    logic [CIW-1:0]  clr_idx_q;
    logic            pend_q;

    logic              ram_we;
    logic [RAM_AW-1:0] ram_waddr;
    logic [7:0]        ram_wdata;
    logic [RAM_AW-1:0] ram_raddr;
    logic [7:0]        ram_rdata;

    logic            kick;
    logic            wd_fire;
    logic [WCW-1:0]  wd_cnt;

    logic [3:0]        page;
    logic [7:0]        off;
    logic [RAM_AW-1:0] tbl_a;
    logic [15:0]       ptr_full;
    logic [14:0]       cur_a;
    logic [7:0]        cur_wbyte;
    logic              data_st;
    logic              wr_en_cur;
    logic [7:0]        rd_byte;
    logic              start_req;
    logic              wd_take;

    // ---------------- submodules ----------------
    vpage_sysram #(.BYTES(RAM_BYTES)) ram_i (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    vpage_watchdog #(.LIMIT(WDOG_CYCLES)) wdog_i (
        .clk  (clk),
        .rst  (rst),
        .kick (kick),
        .cnt  (wd_cnt),
        .fire (wd_fire)
    );

    // ---------------- address arithmetic ----------------
    assign page      = addr_q[11:8];
    assign off       = addr_q[7:0];
    assign tbl_a     = base_q[RAM_AW-1:0] + RAM_AW'({page, 1'b0});
    assign ptr_full  = {ptr_hi_q, ram_rdata};
    assign data_st   = (state_q == S_DATA_HI) || (state_q == S_DATA_LO);
    assign cur_a     = (state_q == S_DATA_LO) ? tgt_q + 15'd1 : tgt_q;
    assign cur_wbyte = (state_q == S_DATA_LO) ? wdat_q[7:0] : wdat_q[15:8];
    assign wr_en_cur = data_st && op_wr_q && !zflag_q;
    assign start_req = host_rd || (host_wr && host_sel);
    assign wd_take   = wd_fire || pend_q;

    // Physical byte read decode (zero for unmapped or blocked page).
    always_comb begin
        rd_byte = 8'h00;
        if (!zflag_q) begin
            if (cur_a < RAM_TOP) begin
                rd_byte = ram_rdata;
            end else if (cur_a == BASE_ADDR) begin
                rd_byte = base_q[15:8];
            end else if (cur_a == BASE_ADDR + 15'd1) begin
                rd_byte = base_q[7:0];
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_CLEAR: begin
                if (clr_idx_q == CLR_LAST) state_d = S_IDLE;
            end
            S_IDLE: begin
                if (wd_take) begin
                    state_d = S_CLEAR;
                end else if (start_req) begin
                    state_d = is_virtual(addr_q) ? S_PTR_HI : S_DATA_HI;
                end
            end
            S_PTR_HI:  state_d = S_PTR_LO;
            S_PTR_LO:  state_d = S_DATA_HI;
            S_DATA_HI: state_d = S_DATA_LO;
            S_DATA_LO: state_d = S_IDLE;
            default:   state_d = S_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_CLEAR;
        else     state_q <= state_d;
    end

    // ---------------- memory port and watchdog restart ----------------
    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = cur_a[RAM_AW-1:0];
        ram_wdata = cur_wbyte;
        ram_raddr = cur_a[RAM_AW-1:0];
        unique case (state_q)
            S_CLEAR: begin
                ram_we    = 1'b1;
                ram_waddr = TBL_RESET[RAM_AW-1:0] + RAM_AW'(clr_idx_q);
                ram_wdata = 8'h00;
            end
            S_PTR_HI:  ram_raddr = tbl_a;
            S_PTR_LO:  ram_raddr = tbl_a + 1'b1;
            S_DATA_HI,
            S_DATA_LO: ram_we = wr_en_cur && (cur_a < RAM_TOP);
            default:   ram_we = 1'b0;
        endcase
    end

    assign kick = wr_en_cur && (state_q == S_DATA_HI) &&
                  (cur_a == KICK_ADDR) && (wdat_q == 16'h0000);

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdat_q    <= '0;
            op_wr_q   <= 1'b0;
            ptr_hi_q  <= '0;
            tgt_q     <= '0;
            zflag_q   <= 1'b0;
            rbuf_q    <= '0;
            rdata_q   <= '0;
            rd_done_q <= 1'b0;
            base_q    <= TBL_RESET;
            clr_idx_q <= '0;
            pend_q    <= 1'b0;
        end else begin
            rd_done_q <= 1'b0;
            if (wd_fire) pend_q <= 1'b1;
            unique case (state_q)
                S_CLEAR: clr_idx_q <= clr_idx_q + 1'b1;
                S_IDLE: begin
                    if (wd_take) begin
                        base_q    <= TBL_RESET;
                        clr_idx_q <= '0;
                        pend_q    <= 1'b0;
                    end else if (host_wr && !host_sel) begin
                        addr_q <= host_wdata[14:0];
                    end else if (start_req) begin
                        op_wr_q <= host_wr;
                        if (host_wr) wdat_q <= host_wdata;
                        tgt_q   <= addr_q;
                        zflag_q <= 1'b0;
                    end
                end
                S_PTR_HI: ptr_hi_q <= ram_rdata;
                S_PTR_LO: begin
                    tgt_q   <= ptr_full[14:0] + {7'd0, off};
                    zflag_q <= ptr_full >= 16'h2000;
                end
                S_DATA_HI: begin
                    rbuf_q <= rd_byte;
                    if (wr_en_cur && cur_a == BASE_ADDR) base_q[15:8] <= cur_wbyte;
                end
                S_DATA_LO: begin
                    if (wr_en_cur && cur_a == BASE_ADDR + 15'd1) base_q[7:0] <= cur_wbyte;
                    if (!op_wr_q) begin
                        rdata_q   <= {rbuf_q, rd_byte};
                        rd_done_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign rd_done    = rd_done_q;
    assign busy       = (state_q != S_IDLE) || wd_take;
    assign wd_reset   = wd_fire;

endmodule

// File: rtl/vpage_xlate_chk.sv
module vpage_xlate_chk #(
    parameter logic [15:0] TBL_RESET = 16'h0100,
    parameter int unsigned WCW       = 11
) (
    input logic                      clk,
    input logic                      rst,
    input vpage_pkg::xl_state_e      state_q,
    input logic [vpage_pkg::CIW-1:0] clr_idx_q,
    input logic [15:0]               base_q,
    input logic                      zflag_q,
    input logic                      op_wr_q,
    input logic [15:0]               host_rdata,
    input logic                      rd_done,
    input logic                      busy,
    input logic                      kick,
    input logic [WCW-1:0]            wd_cnt,
    input logic                      wd_reset
);
    import vpage_pkg::*;

    // R1: clearing ends after the last table byte
    a_r1_clear_exit: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CLEAR && clr_idx_q == CIW'(TBL_BYTES - 1)) |=> state_q == S_IDLE);

    // R10: table clearing always works with the reset base
    a_r10_clear_base: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CLEAR) |-> base_q == TBL_RESET);

    // R10: watchdog reset is a single-cycle pulse
    a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
        wd_reset |=> !wd_reset);

    // R8: a read through a blocked page yields zero
    a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_DATA_LO && zflag_q && !op_wr_q) |=> host_rdata == 16'h0000);

    // R9: a restart write zeroes the watchdog count
    a_r9_kick_restart: assert property (@(posedge clk) disable iff (rst)
        kick |=> wd_cnt == '0);

    // R11: read completion is a single pulse
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    // R11: completion follows a busy cycle
    a_r11_done_from_busy: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> $past(busy));

    // R11: not busy only when idle
    a_r11_idle_not_busy: assert property (@(posedge clk) disable iff (rst)
        !busy |-> state_q == S_IDLE);

endmodule

bind vpage_xlate vpage_xlate_chk #(.TBL_RESET(TBL_RESET), .WCW(WCW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .clr_idx_q  (clr_idx_q),
    .base_q     (base_q),
    .zflag_q    (zflag_q),
    .op_wr_q    (op_wr_q),
    .host_rdata (host_rdata),
    .rd_done    (rd_done),
    .busy       (busy),
    .kick       (kick),
    .wd_cnt     (wd_cnt),
    .wd_reset   (wd_reset)
);

// File: tb/vpage_xlate_tb_top.sv
module vpage_xlate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        rd_done;
    logic        busy;
    logic        wd_reset;

    int checks = 0;
    int fails  = 0;
    int fires  = 0;

    always #2 clk = ~clk;  // 250 MHz

    vpage_xlate dut_i (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_done    (rd_done),
        .busy       (busy),
        .wd_reset   (wd_reset)
    );

    always @(negedge clk) if (!rst && wd_reset) fires++;

    typedef struct packed {
        logic        wr;
        logic [3:0]  req;
        logic [15:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd2, 16'h0010, 16'hA1B2},  // R2 write
        '{1'b0, 4'd2, 16'h0010, 16'hA1B2},  // R2 read back
        '{1'b1, 4'd2, 16'h0012, 16'h3344},
        '{1'b0, 4'd2, 16'h0011, 16'hB233},  // R2 odd address
        '{1'b1, 4'd2, 16'h03FE, 16'h5566},
        '{1'b0, 4'd2, 16'h03FE, 16'h5566},  // R2 top of RAM
        '{1'b0, 4'd3, 16'h8010, 16'hA1B2},  // R3 alias read
        '{1'b1, 4'd3, 16'h8020, 16'h1234},  // R3 alias write
        '{1'b0, 4'd3, 16'h0020, 16'h1234},
        '{1'b0, 4'd5, 16'h1050, 16'h0100},  // R5 reset base
        '{1'b1, 4'd4, 16'h0400, 16'hFFFF},  // R4 ignored write
        '{1'b0, 4'd4, 16'h0400, 16'h0000},
        '{1'b1, 4'd4, 16'h1F00, 16'hABCD},
        '{1'b0, 4'd4, 16'h1F00, 16'h0000},
        '{1'b0, 4'd6, 16'h2010, 16'hA1B2},  // R6 page0 ptr cleared to 0
        '{1'b0, 4'd7, 16'h3010, 16'hA1B2},  // R7 mirror
        '{1'b1, 4'd6, 16'h0102, 16'h0020},  // page1 -> 0x0020
        '{1'b0, 4'd6, 16'h2100, 16'h1234},
        '{1'b0, 4'd7, 16'h3100, 16'h1234},
        '{1'b1, 4'd6, 16'h2105, 16'hCAFE},  // R6 virtual write
        '{1'b0, 4'd6, 16'h0025, 16'hCAFE},
        '{1'b1, 4'd6, 16'h0106, 16'h03F0},  // page3 -> 0x03F0
        '{1'b0, 4'd6, 16'h230E, 16'h5566},
        '{1'b1, 4'd8, 16'h0104, 16'h2000},  // R8 page2 blocked
        '{1'b0, 4'd8, 16'h2210, 16'h0000},
        '{1'b1, 4'd8, 16'h0108, 16'h8000},  // page4 blocked
        '{1'b0, 4'd8, 16'h3410, 16'h0000},
        '{1'b1, 4'd5, 16'h1050, 16'h0200},  // R5 relocate table
        '{1'b0, 4'd5, 16'h1050, 16'h0200},
        '{1'b1, 4'd5, 16'h0200, 16'h0020}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        wait_idle();
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0; host_sel = 1'b0;
    endtask

    task automatic wr16(input logic [15:0] a, input logic [15:0] d);
        host_write(1'b0, a);
        host_write(1'b1, d);
    endtask

    task automatic rd16(input logic [15:0] a, output logic [15:0] v, output int lat);
        host_write(1'b0, a);
        wait_idle();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        lat = 1;
        while (!rd_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        v = host_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int lat;
        int n;

        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1 busy in reset", 16'(busy), 16'h1);
        check("R1 rd_done in reset", 16'(rd_done), 16'h0);
        check("R1 wd_reset in reset", 16'(wd_reset), 16'h0);
        check("R1 rdata in reset", host_rdata, 16'h0000);
        rst = 1'b0;
        n = 0;
        while (busy && n < 100) begin
            @(negedge clk);
            n++;
        end
        check("R1 clear length", 16'(n), 16'd32);

        // Vector table walk
        foreach (VECS[i]) begin
            if (VECS[i].wr) begin
                wr16(VECS[i].addr, VECS[i].data);
            end else begin
                rd16(VECS[i].addr, v, lat);
                check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].data);
            end
        end
        rd16(16'h2000, v, lat);
        check("R5 new base page0", v, 16'h1234);
        rd16(16'h3000, v, lat);
        check("R7 new base mirror", v, 16'h1234);

        // R11 latency
        rd16(16'h0010, v, lat);
        check("R11 physical latency", 16'(lat), 16'd3);
        rd16(16'h2000, v, lat);
        check("R11 virtual latency", 16'(lat), 16'd5);

        // R9 restart keeps watchdog quiet; R10 expiry
        wr16(16'h1040, 16'h0000);
        repeat (1800) @(negedge clk);
        check("R9 no expiry after restart", 16'(fires), 16'd0);
        wr16(16'h1040, 16'h0005);  // nonzero: not a restart
        repeat (300) @(negedge clk);
        check("R9 nonzero write no restart", 16'(fires), 16'd1);
        rd16(16'h1050, v, lat);
        check("R10 base reloaded", v, 16'h0100);
        rd16(16'h0102, v, lat);
        check("R10 table cleared", v, 16'h0000);
        rd16(16'h2110, v, lat);
        check("R10 other RAM kept", v, 16'hA1B2);

        // R9 repeated restarts
        wr16(16'h1040, 16'h0000);
        repeat (1500) @(negedge clk);
        wr16(16'h1040, 16'h0000);
        repeat (1000) @(negedge clk);
        check("R9 second restart", 16'(fires), 16'd1);
        repeat (1100) @(negedge clk);
        check("R10 second expiry", 16'(fires), 16'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule